// File: doc/BRIEF.md
# Bidirectional Interface Latch Bank

A bank of six general-purpose pins that a line card uses to watch and drive the control leads of a subscriber line circuit. Each pin is either an input or an output. A direction register chooses which. A content register holds the level each output pin drives and the level last sampled on each input pin. Both registers are loaded through a byte-wide write port, and either one can be read back as a byte.

The serial control port that feeds this block raises a one-cycle sample strobe during each of its transfers. On that strobe, every input-configured pin is copied into the content register, using its value after a two-flop synchronizer. Between strobes, the input bits of the content register hold their value, whatever the pins do. In both register bytes, pin 0 sits in the most significant bit and the pins run downward from there. The two lowest bits carry no pin and always read as zero.

The block has no power-state input. Its registers and driven outputs are unaffected by the power state of the surrounding device and change only on reset, on a write, or on a sample strobe.

Top module: `ilb_latch_bank`

## Requirements
- R1: After synchronous reset, all direction bits are 0. Every pin is then an input: `pin_oe` is 0, `pin_out` is 0, and reading either register returns 0x00.
- R2: A write with `wr_sel`=0 loads the direction register. Byte bit 7-i controls pin i (bit 7 is pin 0, bit 2 is pin 5), and a 1 makes the pin an output. `pin_oe` shows the new value in the cycle after the write edge.
- R3: With `rd_sel`=0, `rd_data` returns the direction register in the R2 layout. With either `rd_sel` value, bits 1 and 0 of `rd_data` read as 0 no matter what was written there.
- R4: For each output pin, `pin_out[i]` equals content bit i. For each input pin, `pin_out[i]` is 0.
- R5: A write with `wr_sel`=1 loads the content register in the same layout as R2, and only into the bits of pins that are currently outputs. Content bits of input pins are left unchanged.
- R6: On a cycle with `capture`=1, the synchronized level of each input pin is stored into its content bit. When `capture` is 0, the content bits of input pins keep their value regardless of `pin_in`.
- R7: A change on `pin_in` is seen by a capture only if it was present at least two rising edges before the capture edge. A change applied one edge earlier is not yet seen, and the old level is captured.
- R8: A capture never alters the content bits of output pins.
- R9: With `rd_sel`=1, `rd_data` returns every content bit, both captured inputs and programmed outputs, in the R2 layout.
- R10: When a pin is switched from output to input, its content bit keeps the last programmed value until the next capture. When a pin is switched from input to output, it drives the last captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 selects the direction register, 1 selects the content register |
| wr_data | input | 8 | Write byte, pin 0 in bit 7 |
| capture | input | 1 | Sample strobe from the control port |
| rd_sel | input | 1 | Readback source: 0 selects direction, 1 selects content |
| rd_data | output | 8 | Readback byte |
| pin_in | input | 6 | Levels sensed on the pins |
| pin_oe | output | 6 | Per-pin output enable |
| pin_out | output | 6 | Per-pin driven level |

## Verification
Register writes show up on `pin_oe`, `pin_out` and the combinational `rd_data` one edge after the write. The bench drives each stimulus on a falling edge and samples on the next falling edge, which is half a cycle after that register edge.

A pin level reaches the content register three edges after it is applied: two edges for the synchronizer and one for the capture. The bench therefore lets pin levels settle for at least two edges before raising `capture`. For R7 it deliberately raises `capture` one edge early and expects the old level, then raises it at the minimum spacing and expects the new level.

The sweep covers all 64 direction settings. For each setting, the content and pin patterns are derived arithmetically from the direction value.

// File: rtl/ilb_pkg.sv
package ilb_pkg;

    localparam int unsigned PIN_COUNT = 6;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned SPARE_W   = BYTE_W - PIN_COUNT;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef logic [PIN_COUNT-1:0] pin_vec_t;
    typedef logic [BYTE_W-1:0]    reg_byte_t;

    typedef enum logic {
        SEL_DIR   = 1'b0,
        SEL_LATCH = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic     wr_dir;
        logic     wr_latch;
        pin_vec_t wr_pins;
    } wr_cmd_t;

    // pin i occupies byte bit (BYTE_W-1-i); spare low bits are zero
    function automatic reg_byte_t pins_to_byte(input pin_vec_t p);
        reg_byte_t b;
        b = '0;
        for (int i = 0; i < PIN_COUNT; i++) begin
            b[BYTE_W-1-i] = p[i];
        end
        return b;
    endfunction

    function automatic pin_vec_t byte_to_pins(input reg_byte_t b);
        pin_vec_t p;
        for (int i = 0; i < PIN_COUNT; i++) begin
            p[i] = b[BYTE_W-1-i];
        end
        return p;
    endfunction

endpackage

// File: rtl/ilb_sync.sv
module ilb_sync #(
    parameter int unsigned WIDTH  = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/ilb_dir_reg.sv
module ilb_dir_reg
    import ilb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wr_cmd_t  cmd,
    output pin_vec_t dir_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
        end else if (cmd.wr_dir) begin
            dir_q <= cmd.wr_pins;
        end
    end

endmodule

// File: rtl/ilb_latch_reg.sv
module ilb_latch_reg
    import ilb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wr_cmd_t  cmd,
    input  logic     capture,
    input  pin_vec_t sync_pins,
    input  pin_vec_t dir_q,
    output pin_vec_t ilr_q
);

    pin_vec_t ilr_d;

    generate
        for (genvar i = 0; i < PIN_COUNT; i++) begin : g_bit
            always_comb begin
                ilr_d[i] = ilr_q[i];
                if (dir_q[i]) begin
                    if (cmd.wr_latch) ilr_d[i] = cmd.wr_pins[i];
                end else begin
                    if (capture) ilr_d[i] = sync_pins[i];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ilr_q <= '0;
        else     ilr_q <= ilr_d;
    end

endmodule

// File: rtl/ilb_read_mux.sv
module ilb_read_mux
    import ilb_pkg::*;
(
    input  reg_sel_e  sel,
    input  pin_vec_t  dir_q,
    input  pin_vec_t  ilr_q,
    output reg_byte_t rd_byte
);

    always_comb begin
        unique case (sel)
            SEL_DIR:   rd_byte = pins_to_byte(dir_q);
            SEL_LATCH: rd_byte = pins_to_byte(ilr_q);
            default:   rd_byte = '0;
        endcase
    end

endmodule

// File: rtl/ilb_latch_bank.sv
module ilb_latch_bank
    import ilb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic                 capture,
    input  logic                 rd_sel,
    output logic [BYTE_W-1:0]    rd_data,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic [PIN_COUNT-1:0] pin_out
);

    wr_cmd_t  cmd;
    pin_vec_t sync_pins;
    pin_vec_t dir_q;
    pin_vec_t ilr_q;
    reg_sel_e rd_src;

    always_comb begin
        cmd.wr_dir   = wr_en && (reg_sel_e'(wr_sel) == SEL_DIR);
        cmd.wr_latch = wr_en && (reg_sel_e'(wr_sel) == SEL_LATCH);
        cmd.wr_pins  = byte_to_pins(wr_data);
    end

    assign rd_src = reg_sel_e'(rd_sel);

    ilb_sync #(
        .WIDTH  (PIN_COUNT),
        .STAGES (SYNC_DEPTH)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (sync_pins)
    );

    ilb_dir_reg u_dir (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .dir_q (dir_q)
    );

    ilb_latch_reg u_latch (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .capture   (capture),
        .sync_pins (sync_pins),
        .dir_q     (dir_q),
        .ilr_q     (ilr_q)
    );

    ilb_read_mux u_rd (
        .sel     (rd_src),
        .dir_q   (dir_q),
        .ilr_q   (ilr_q),
        .rd_byte (rd_data)
    );

    assign pin_oe  = dir_q;
    assign pin_out = ilr_q & dir_q;

endmodule

// File: rtl/ilb_checker.sv
module ilb_checker
    import ilb_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic                 wr_sel,
    input logic [BYTE_W-1:0]    wr_data,
    input logic                 capture,
    input logic [BYTE_W-1:0]    rd_data,
    input logic [PIN_COUNT-1:0] pin_oe,
    input logic [PIN_COUNT-1:0] pin_out,
    input logic [PIN_COUNT-1:0] ilr_q,
    input logic [PIN_COUNT-1:0] dir_q
);

    // R1
    reset_inputs_chk: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) |=> (pin_oe == byte_to_pins($past(wr_data))));

    // R3
    spare_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[SPARE_W-1:0] == '0);

    // R4
    input_not_driven_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == '0);

    // R5
    write_keeps_inputs_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel) |=> ((ilr_q & ~dir_q) == $past(ilr_q & ~dir_q)) || $past(capture));

    // R6
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!capture && !(wr_en && wr_sel)) |=> $stable(ilr_q));

    // R8
    capture_keeps_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        (capture && !wr_en) |=> ((ilr_q & dir_q) == $past(ilr_q & dir_q)));

endmodule

bind ilb_latch_bank ilb_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .capture (capture),
    .rd_data (rd_data),
    .pin_oe  (pin_oe),
    .pin_out (pin_out),
    .ilr_q   (ilr_q),
    .dir_q   (dir_q)
);

// File: tb/ilb_latch_bank_test.sv
module ilb_latch_bank_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       capture = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic [5:0] pin_in = '0;
    logic [5:0] pin_oe;
    logic [5:0] pin_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [5:0] m_dir = '0;
    logic [5:0] m_ilr = '0;

    always #5 clk = ~clk;

    ilb_latch_bank uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .capture(capture), .rd_sel(rd_sel), .rd_data(rd_data),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    function automatic logic [7:0] as_byte(input logic [5:0] p);
        logic [7:0] b = '0;
        for (int i = 0; i < 6; i++) b[7-i] = p[i];
        return b;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) m_ilr = (m_ilr & ~m_dir) | (data[7:2] == 6'h0 ? 6'h0 : 6'h0) | (pins_of(data) & m_dir);
        else     m_dir = pins_of(data);
    endtask

    function automatic logic [5:0] pins_of(input logic [7:0] b);
        logic [5:0] p;
        for (int i = 0; i < 6; i++) p[i] = b[7-i];
        return p;
    endfunction

    task automatic strobe();
        @(negedge clk);
        capture = 1'b1;
        @(negedge clk);
        capture = 1'b0;
    endtask

    task automatic read_and_check(input string req_d, input string req_c);
        rd_sel = 1'b0; #1;
        check(req_d, rd_data, as_byte(m_dir));
        rd_sel = 1'b1; #1;
        check(req_c, rd_data, as_byte(m_ilr));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 oe", {2'b0, pin_oe}, 8'h00);
        check("R1 out", {2'b0, pin_out}, 8'h00);
        read_and_check("R1 dir read", "R1 latch read");

        // R3 spare bits written as ones read back zero
        write_reg(1'b0, 8'h03);
        read_and_check("R3 dir spare", "R9 latch spare");

        // R2 bit order: byte bit 7 is pin 0
        write_reg(1'b0, 8'h80);
        check("R2 pin0", {2'b0, pin_oe}, 8'h01);
        write_reg(1'b0, 8'h04);
        check("R2 pin5", {2'b0, pin_oe}, 8'h20);

        // R7 synchronizer latency: all pins inputs
        write_reg(1'b0, 8'h00);
        pin_in = 6'h00;
        repeat (4) @(negedge clk);
        strobe();
        m_ilr = 6'h00;
        @(negedge clk);
        pin_in = 6'h3F;
        capture = 1'b1;          // capture edge one edge after the change
        @(negedge clk);
        capture = 1'b0;
        rd_sel = 1'b1; #1;
        check("R7 too early", rd_data, as_byte(6'h00));
        @(negedge clk);
        pin_in = 6'h15;
        @(negedge clk);
        capture = 1'b1;          // second edge after change: still old
        @(negedge clk);
        capture = 1'b0;
        rd_sel = 1'b1; #1;
        check("R7 one edge", rd_data, as_byte(6'h3F));
        @(negedge clk);
        pin_in = 6'h2A;
        @(negedge clk);
        @(negedge clk);
        capture = 1'b1;          // third edge after change: new level
        @(negedge clk);
        capture = 1'b0;
        rd_sel = 1'b1; #1;
        check("R7 two edges", rd_data, as_byte(6'h2A));
        m_ilr = 6'h2A;

        // R6 pins change without strobe: content holds
        pin_in = 6'h11;
        repeat (5) @(negedge clk);
        rd_sel = 1'b1; #1;
        check("R6 hold", rd_data, as_byte(m_ilr));

        // R10 input->output drives captured value
        write_reg(1'b0, 8'hFC);
        check("R10 in to out", {2'b0, pin_out}, {2'b0, 6'h2A});
        write_reg(1'b1, as_byte(6'h05));
        write_reg(1'b0, 8'h00);
        read_and_check("R10 dir", "R10 out to in keeps");
        check("R4 no drive", {2'b0, pin_out}, 8'h00);

        // sweep all direction values
        for (int d = 0; d < 64; d++) begin
            logic [5:0] c;
            logic [5:0] p;
            c = 6'((d * 37 + 11) & 63);
            p = 6'((d * 13 + 5) & 63);
            write_reg(1'b0, as_byte(6'(d)));
            check("R2 oe", {2'b0, pin_oe}, {2'b0, 6'(d)});
            write_reg(1'b1, as_byte(c));
            check("R4 out", {2'b0, pin_out}, {2'b0, m_ilr & m_dir});
            read_and_check("R3 dir", "R5 after write");
            pin_in = p;
            repeat (3) @(negedge clk);
            strobe();
            m_ilr = (m_ilr & m_dir) | (p & ~m_dir);
            read_and_check("R3 dir", "R6 R8 R9 after capture");
            check("R4 out post", {2'b0, pin_out}, {2'b0, m_ilr & m_dir});
        end

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_dir = '0; m_ilr = '0;
        check("R1 oe again", {2'b0, pin_oe}, 8'h00);
        read_and_check("R1 dir again", "R1 latch again");

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule